// File: doc/BRIEF.md
# Serial Receive Queue with Level Interrupts

This block is the receive half of an asynchronous serial port. It oversamples the incoming line on an external tick, assembles each frame into a character and pushes that character into a 32-entry queue. Every queue entry keeps its own parity, framing and break flags, so software sees each error next to the character it belongs to. Sticky copies of those flags, plus an overflow flag, sit in a status word and are cleared by writing one.

Interrupt and flow-control outputs follow the fill level. A coded threshold raises a data-available interrupt. A second coded threshold drops the request-to-send output so the far end stops sending before the queue runs out of room. An idle timer raises a timeout interrupt when characters sit unread for a programmed number of bit periods. Software works through a four-word register window: read/pop, configuration, timeout value, and status with write-one-to-clear flags. A separate flush input empties the queue in one cycle.

Top module: `uart_rx_fifo_irq`

## Requirements
- R1: A frame is a low start bit, 8 data bits LSB first, an optional parity bit (configuration bit 14) and a stop bit, all sampled at 16 ticks per bit. A read of address 0 returns the head entry: character in bits 7:0, parity error in bit 8, framing error in bit 9, break in bit 10, entry valid in bit 11. When regRdEn is high the entry is popped at the next edge.
- R2: The queue holds 32 entries. Status (address 3) shows the count in bits 5:0, empty in bit 6, full in bit 7. The interrupt in bit 12, the timeout interrupt in bit 13 and the RTS pin in bit 14 mirror the outputs.
- R3: A character that arrives while the queue is full and is not being popped is discarded. It sets the sticky overflow flag (status bit 11), and the count stays at 32.
- R4: The data-available trigger code (configuration bits 3:0) maps 0→1, 1→4, 2→8, 3→14, 4→30 entries. Every other code means 30. dataIrq is high while configuration bit 8 is set and count ≥ that level. It falls as soon as the count drops below the level.
- R5: With automatic RTS on (configuration bit 11), the request is active while count < level of the RTS code (bits 7:4, same mapping) and inactive at or above it. With automatic RTS off, the request follows bit 12. The pin is high when the request is active if bit 13 is set, and low when the request is active if bit 13 is clear.
- R6: With the timer enabled (configuration bit 10), the timer counts bit periods while the queue is non-empty and the receiver is idle. A push or a pop reloads it to zero. toutIrq is high while bit 9 is set and the count equals the timeout value (address 2).
- R7: With parity on, configuration bit 15 selects even (1) or odd (0). A mismatch sets the entry's parity flag and the sticky status bit 8.
- R8: A low stop bit that is not a break sets the entry's framing flag and the sticky status bit 9. The receiver then waits for the line to go high before it looks for the next start bit.
- R9: A line held low through a whole frame, stop bit included, stores exactly one entry. That entry has a zero character and the break flag set, with no framing flag, and it sets the sticky status bit 10.
- R10: A flush pulse empties the queue and zeroes the count in one cycle. The sticky error flags are left unchanged.
- R11: A write to address 3 clears only the sticky flags in bits 11:8 that are written as one. Bits written as zero keep their state.
- R12: A pop of an empty queue changes nothing, and address 0 then reads zero.
- R13: After reset the queue is empty, the configuration and timeout value are zero, both interrupts are low and the RTS pin is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| sampleTick | input | 1 | Oversampling strobe, 16 per bit period |
| rxLine | input | 1 | Serial receive line, idle high |
| fifoFlush | input | 1 | One-cycle queue flush |
| regWrEn | input | 1 | Register write strobe |
| regRdEn | input | 1 | Register read strobe (pops at address 0) |
| regAddr | input | 2 | Register word address |
| regWrData | input | 16 | Register write data |
| regRdData | output | 16 | Register read data, combinational |
| dataIrq | output | 1 | Data-available interrupt |
| toutIrq | output | 1 | Receive timeout interrupt |
| rtsPin | output | 1 | Request-to-send pin |

## Verification
A wrong count or pointer shows at the ports within one character. Either the status count differs on the next status read, or the popped character comes out in the wrong order. A wrong threshold decode flips dataIrq or rtsPin at the exact fill level where the check is placed, so each level is probed on both sides of its boundary. A wrong flag path or a wrong clear mask shows on the next head read or status read after the faulty frame or write. A timer that counts wrong raises toutIrq early or late by whole bit periods, so it is sampled well inside the window before it should fire and again well after.

// File: rtl/rxq_pkg.sv
package rxq_pkg;

  localparam int CHAR_W = 8;
  localparam int REG_W  = 16;

  typedef struct packed {
    logic [CHAR_W-1:0] ch;
    logic              pe;
    logic              fe;
    logic              brk;
  } rxEntry_t;

  // Strobes from control to the queue datapath.
  // clrMask bit order: {overflow, break, framing, parity}
  typedef struct packed {
    logic       push;
    rxEntry_t   entry;
    logic       pop;
    logic       flush;
    logic [3:0] clrMask;
  } rxStrobe_t;

  typedef enum logic [2:0] {
    RX_IDLE, RX_START, RX_DATA, RX_PAR, RX_STOP, RX_HOLD
  } rxState_t;

  function automatic logic [7:0] trigLevel(input logic [3:0] code);
    case (code)
      4'd0:    trigLevel = 8'd1;
      4'd1:    trigLevel = 8'd4;
      4'd2:    trigLevel = 8'd8;
      4'd3:    trigLevel = 8'd14;
      default: trigLevel = 8'd30;
    endcase
  endfunction

endpackage

// File: rtl/rxq_data.sv
module rxq_data
  import rxq_pkg::*;
#(
  parameter int DEPTH = 32,
  parameter int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  rxStrobe_t        strobe,
  output logic [CNT_W-1:0] count,
  output logic             empty,
  output logic             full,
  output rxEntry_t         head,
  output logic [3:0]       stickyFlags
);

  localparam int PTR_W = $clog2(DEPTH);

  rxEntry_t          mem [DEPTH];
  logic [PTR_W-1:0]  wrPtr;
  logic [PTR_W-1:0]  rdPtr;
  logic              doPush;
  logic              doPop;
  logic              ovfHit;
  logic [3:0]        setFlags;

  assign empty  = (count == '0);
  assign full   = (count == CNT_W'(DEPTH));
  assign doPop  = strobe.pop && !empty;
  assign doPush = strobe.push && (!full || doPop);
  assign ovfHit = strobe.push && full && !doPop;
  assign head   = empty ? '0 : mem[rdPtr];

  assign setFlags = {ovfHit,
                     doPush && strobe.entry.brk,
                     doPush && strobe.entry.fe,
                     doPush && strobe.entry.pe};

  always_ff @(posedge clk) begin
    if (doPush && !strobe.flush) mem[wrPtr] <= strobe.entry;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else if (strobe.flush) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (doPush) wrPtr <= wrPtr + 1'b1;
      if (doPop)  rdPtr <= rdPtr + 1'b1;
      case ({doPush, doPop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  // Set wins over a clear in the same cycle.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stickyFlags <= '0;
    else       stickyFlags <= (stickyFlags & ~strobe.clrMask) | setFlags;
  end

  a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.push && full && !strobe.pop && !strobe.flush)
      |=> (stickyFlags[3] && count == CNT_W'(DEPTH)));

  a_r2_full_empty_excl: assert property (@(posedge clk) disable iff (!rstN)
    !(full && empty));

  a_r10_flush_empties: assert property (@(posedge clk) disable iff (!rstN)
    strobe.flush |=> (empty && count == '0));

  a_r12_pop_empty: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.pop && !strobe.push && empty && !strobe.flush) |=> empty);

endmodule

// File: rtl/rxq_ctrl.sv
module rxq_ctrl
  import rxq_pkg::*;
#(
  parameter int DEPTH      = 32,
  parameter int OVERSAMPLE = 16,
  parameter int TOUT_W     = 8,
  parameter int CNT_W      = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             sampleTick,
  input  logic             rxLine,
  input  logic             fifoFlush,
  input  logic             regWrEn,
  input  logic             regRdEn,
  input  logic [1:0]       regAddr,
  input  logic [REG_W-1:0] regWrData,
  output logic [REG_W-1:0] regRdData,
  input  logic [CNT_W-1:0] count,
  input  logic             empty,
  input  logic             full,
  input  rxEntry_t         head,
  input  logic [3:0]       stickyFlags,
  output rxStrobe_t        strobe,
  output logic             dataIrq,
  output logic             toutIrq,
  output logic             rtsPin
);

  localparam int OS_W  = $clog2(OVERSAMPLE);
  localparam int HALF  = OVERSAMPLE / 2;
  localparam int BIT_W = $clog2(CHAR_W);

  // ---------------- configuration ----------------
  logic [REG_W-1:0]  cfgReg;
  logic [TOUT_W-1:0] toutVal;

  logic [3:0] irqCode, rtsCode;
  logic dataIrqEn, toutIrqEn, toutCntEn, autoRtsEn;
  logic rtsManual, rtsActiveHigh, parityEn, parityEven;

  assign irqCode       = cfgReg[3:0];
  assign rtsCode       = cfgReg[7:4];
  assign dataIrqEn     = cfgReg[8];
  assign toutIrqEn     = cfgReg[9];
  assign toutCntEn     = cfgReg[10];
  assign autoRtsEn     = cfgReg[11];
  assign rtsManual     = cfgReg[12];
  assign rtsActiveHigh = cfgReg[13];
  assign parityEn      = cfgReg[14];
  assign parityEven    = cfgReg[15];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfgReg  <= '0;
      toutVal <= '0;
    end else if (regWrEn) begin
      case (regAddr)
        2'd1:    cfgReg  <= regWrData;
        2'd2:    toutVal <= regWrData[TOUT_W-1:0];
        default: ;
      endcase
    end
  end

  // ---------------- frame receiver ----------------
  rxState_t          rxState;
  logic              rxS1, rxS2;
  logic [OS_W-1:0]   osCnt;
  logic [BIT_W-1:0]  bitIdx;
  logic [CHAR_W-1:0] shiftReg;
  logic              parBit;
  logic              pushQ;
  rxEntry_t          pushEntry;
  rxEntry_t          frameEntry;
  logic              isBreak;
  logic              rxBusy;
  logic              osEnd;

  assign osEnd  = (osCnt == OS_W'(OVERSAMPLE - 1));
  assign rxBusy = (rxState != RX_IDLE);

  always_comb begin
    isBreak        = !rxS2 && (shiftReg == '0) && (!parityEn || !parBit);
    frameEntry.ch  = shiftReg;
    frameEntry.brk = isBreak;
    frameEntry.fe  = !rxS2 && !isBreak;
    frameEntry.pe  = !isBreak && parityEn && ((^shiftReg) ^ parBit ^ !parityEven);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxS1      <= 1'b1;
      rxS2      <= 1'b1;
      rxState   <= RX_IDLE;
      osCnt     <= '0;
      bitIdx    <= '0;
      shiftReg  <= '0;
      parBit    <= 1'b0;
      pushQ     <= 1'b0;
      pushEntry <= '0;
    end else begin
      rxS1  <= rxLine;
      rxS2  <= rxS1;
      pushQ <= 1'b0;
      if (sampleTick) begin
        case (rxState)
          RX_IDLE: begin
            if (!rxS2) begin
              rxState <= RX_START;
              osCnt   <= '0;
            end
          end
          RX_START: begin
            if (osCnt == OS_W'(HALF - 1)) begin
              osCnt   <= '0;
              bitIdx  <= '0;
              rxState <= rxS2 ? RX_IDLE : RX_DATA;
            end else begin
              osCnt <= osCnt + 1'b1;
            end
          end
          RX_DATA: begin
            if (osEnd) begin
              osCnt    <= '0;
              shiftReg <= {rxS2, shiftReg[CHAR_W-1:1]};
              bitIdx   <= bitIdx + 1'b1;
              if (bitIdx == BIT_W'(CHAR_W - 1))
                rxState <= parityEn ? RX_PAR : RX_STOP;
            end else begin
              osCnt <= osCnt + 1'b1;
            end
          end
          RX_PAR: begin
            if (osEnd) begin
              osCnt   <= '0;
              parBit  <= rxS2;
              rxState <= RX_STOP;
            end else begin
              osCnt <= osCnt + 1'b1;
            end
          end
          RX_STOP: begin
            if (osEnd) begin
              osCnt     <= '0;
              pushQ     <= 1'b1;
              pushEntry <= frameEntry;
              parBit    <= 1'b0;
              rxState   <= rxS2 ? RX_IDLE : RX_HOLD;
            end else begin
              osCnt <= osCnt + 1'b1;
            end
          end
          RX_HOLD: begin
            if (rxS2) rxState <= RX_IDLE;
          end
          default: rxState <= RX_IDLE;
        endcase
      end
    end
  end

  // ---------------- strobes to datapath ----------------
  always_comb begin
    strobe.push    = pushQ;
    strobe.entry   = pushEntry;
    strobe.pop     = regRdEn && (regAddr == 2'd0);
    strobe.flush   = fifoFlush;
    strobe.clrMask = (regWrEn && regAddr == 2'd3) ? regWrData[11:8] : 4'b0000;
  end

  // ---------------- idle timeout ----------------
  logic [OS_W-1:0]   bitDiv;
  logic              bitPulse;
  logic [TOUT_W-1:0] toutCnt;
  logic              toutReload;

  assign bitPulse   = sampleTick && (bitDiv == OS_W'(OVERSAMPLE - 1));
  assign toutReload = !toutCntEn || empty || strobe.push || strobe.pop || rxBusy || fifoFlush;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bitDiv  <= '0;
      toutCnt <= '0;
    end else begin
      if (sampleTick) bitDiv <= bitPulse ? '0 : bitDiv + 1'b1;
      if (toutReload)                           toutCnt <= '0;
      else if (bitPulse && toutCnt != toutVal)  toutCnt <= toutCnt + 1'b1;
    end
  end

  assign toutIrq = toutIrqEn && toutCntEn && !empty && (toutCnt == toutVal);

  // ---------------- level outputs ----------------
  logic [CNT_W-1:0] irqLevel, rtsLevel;
  logic             rtsRequest;

  assign irqLevel   = CNT_W'(trigLevel(irqCode));
  assign rtsLevel   = CNT_W'(trigLevel(rtsCode));
  assign dataIrq    = dataIrqEn && (count >= irqLevel);
  assign rtsRequest = autoRtsEn ? (count < rtsLevel) : rtsManual;
  assign rtsPin     = rtsActiveHigh ? rtsRequest : !rtsRequest;

  // ---------------- register read ----------------
  always_comb begin
    regRdData = '0;
    case (regAddr)
      2'd0: begin
        regRdData[CHAR_W-1:0] = head.ch;
        regRdData[8]          = head.pe;
        regRdData[9]          = head.fe;
        regRdData[10]         = head.brk;
        regRdData[11]         = !empty;
      end
      2'd1: regRdData = cfgReg;
      2'd2: regRdData[TOUT_W-1:0] = toutVal;
      default: begin
        regRdData[5:0]  = 6'(count);
        regRdData[6]    = empty;
        regRdData[7]    = full;
        regRdData[11:8] = stickyFlags;
        regRdData[12]   = dataIrq;
        regRdData[13]   = toutIrq;
        regRdData[14]   = rtsPin;
      end
    endcase
  end

  a_r1_single_push: assert property (@(posedge clk) disable iff (!rstN)
    strobe.push |=> !strobe.push);

  a_r9_break_zero: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.push && strobe.entry.brk) |-> (strobe.entry.ch == '0 && !strobe.entry.fe));

  a_r6_tout_pop: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.pop && toutVal != '0) |=> !toutIrq);

  a_r5_rts_full: assert property (@(posedge clk) disable iff (!rstN)
    (autoRtsEn && full) |-> (rtsPin == !rtsActiveHigh));

endmodule

// File: rtl/uart_rx_fifo_irq.sv
module uart_rx_fifo_irq
  import rxq_pkg::*;
#(
  parameter int DEPTH      = 32,
  parameter int OVERSAMPLE = 16,
  parameter int TOUT_W     = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             sampleTick,
  input  logic             rxLine,
  input  logic             fifoFlush,
  input  logic             regWrEn,
  input  logic             regRdEn,
  input  logic [1:0]       regAddr,
  input  logic [REG_W-1:0] regWrData,
  output logic [REG_W-1:0] regRdData,
  output logic             dataIrq,
  output logic             toutIrq,
  output logic             rtsPin
);

  localparam int CNT_W = $clog2(DEPTH + 1);

  rxStrobe_t        strobe;
  logic [CNT_W-1:0] count;
  logic             empty;
  logic             full;
  rxEntry_t         head;
  logic [3:0]       stickyFlags;

  rxq_ctrl #(
    .DEPTH(DEPTH), .OVERSAMPLE(OVERSAMPLE), .TOUT_W(TOUT_W), .CNT_W(CNT_W)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .sampleTick(sampleTick), .rxLine(rxLine),
    .fifoFlush(fifoFlush), .regWrEn(regWrEn), .regRdEn(regRdEn),
    .regAddr(regAddr), .regWrData(regWrData), .regRdData(regRdData),
    .count(count), .empty(empty), .full(full), .head(head),
    .stickyFlags(stickyFlags), .strobe(strobe),
    .dataIrq(dataIrq), .toutIrq(toutIrq), .rtsPin(rtsPin)
  );

  rxq_data #(
    .DEPTH(DEPTH), .CNT_W(CNT_W)
  ) u_data (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .count(count), .empty(empty), .full(full), .head(head),
    .stickyFlags(stickyFlags)
  );

endmodule

// File: tb/test_uart_rx_fifo_irq.sv
module test_uart_rx_fifo_irq;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        sampleTick = 1'b1;
  logic        rxLine = 1'b1;
  logic        fifoFlush = 1'b0;
  logic        regWrEn = 1'b0;
  logic        regRdEn = 1'b0;
  logic [1:0]  regAddr = 2'd3;
  logic [15:0] regWrData = '0;
  logic [15:0] regRdData;
  logic        dataIrq, toutIrq, rtsPin;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  localparam logic [15:0] C_DIRQ  = 16'h0100;
  localparam logic [15:0] C_TIRQ  = 16'h0200;
  localparam logic [15:0] C_TCNT  = 16'h0400;
  localparam logic [15:0] C_ARTS  = 16'h0800;
  localparam logic [15:0] C_MRTS  = 16'h1000;
  localparam logic [15:0] C_RHIGH = 16'h2000;
  localparam logic [15:0] C_PAR   = 16'h4000;
  localparam logic [15:0] C_EVEN  = 16'h8000;

  always #5 clk = ~clk;

  uart_rx_fifo_irq i_uart_rx_fifo_irq (
    .clk(clk), .rstN(rstN), .sampleTick(sampleTick), .rxLine(rxLine),
    .fifoFlush(fifoFlush), .regWrEn(regWrEn), .regRdEn(regRdEn),
    .regAddr(regAddr), .regWrData(regWrData), .regRdData(regRdData),
    .dataIrq(dataIrq), .toutIrq(toutIrq), .rtsPin(rtsPin)
  );

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic regWrite(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    regAddr = a; regWrData = d; regWrEn = 1'b1;
    @(negedge clk);
    regWrEn = 1'b0; regAddr = 2'd3;
  endtask

  task automatic regRead(input logic [1:0] a, output logic [15:0] d);
    @(negedge clk);
    regAddr = a; regRdEn = 1'b1;
    #1 d = regRdData;
    @(negedge clk);
    regRdEn = 1'b0; regAddr = 2'd3;
  endtask

  task automatic flush();
    @(negedge clk); fifoFlush = 1'b1;
    @(negedge clk); fifoFlush = 1'b0;
  endtask

  task automatic sendFrame(input logic [7:0] d, input bit withPar,
                           input bit parVal, input bit stopVal);
    @(negedge clk);
    rxLine = 1'b0;
    repeat (16) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      rxLine = d[i];
      repeat (16) @(negedge clk);
    end
    if (withPar) begin
      rxLine = parVal;
      repeat (16) @(negedge clk);
    end
    rxLine = stopVal;
    repeat (16) @(negedge clk);
    rxLine = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [15:0] d;
    regRead(2'd3, d);
    check("R13", "status after reset", d, 32'h4040);
    check("R13", "dataIrq after reset", dataIrq, 0);
    check("R13", "toutIrq after reset", toutIrq, 0);
    check("R13", "rtsPin after reset", rtsPin, 1);
    regRead(2'd1, d);
    check("R13", "config after reset", d, 0);
  endtask

  task automatic t_basic();
    logic [15:0] d;
    regWrite(2'd1, C_DIRQ);  // code 0 -> level 1
    check("R4", "irq at count 0 code0", dataIrq, 0);
    sendFrame(8'hA5, 0, 0, 1);
    check("R4", "irq at count 1 code0", dataIrq, 1);
    sendFrame(8'h3C, 0, 0, 1);
    regRead(2'd3, d);
    check("R2", "count after two", d[7:0], 8'h02);
    regRead(2'd0, d);
    check("R1", "first entry", d, 32'h08A5);
    regRead(2'd0, d);
    check("R1", "second entry", d, 32'h083C);
    regRead(2'd3, d);
    check("R2", "empty after pops", d[7:0], 8'h40);
    check("R4", "irq falls when empty", dataIrq, 0);
  endtask

  task automatic t_parity();
    logic [15:0] d;
    regWrite(2'd1, C_PAR | C_EVEN);
    sendFrame(8'h07, 1, 1, 1);   // correct even parity
    sendFrame(8'h07, 1, 0, 1);   // wrong
    regRead(2'd0, d);
    check("R7", "good parity entry", d, 32'h0807);
    regRead(2'd0, d);
    check("R7", "bad parity entry", d, 32'h0907);
    regWrite(2'd1, C_PAR);       // odd
    sendFrame(8'h07, 1, 0, 1);   // correct odd
    regRead(2'd0, d);
    check("R7", "odd parity ok entry", d, 32'h0807);
    regRead(2'd3, d);
    check("R7", "sticky parity", d[11:8], 4'b0001);
    regWrite(2'd3, 16'h0000);
    regRead(2'd3, d);
    check("R11", "zero write keeps flag", d[11:8], 4'b0001);
    regWrite(2'd3, 16'h0100);
    regRead(2'd3, d);
    check("R11", "one write clears flag", d[11:8], 4'b0000);
  endtask

  task automatic t_frame();
    logic [15:0] d;
    regWrite(2'd1, 16'h0000);
    sendFrame(8'h55, 0, 0, 0);
    sendFrame(8'h12, 0, 0, 1);
    regRead(2'd0, d);
    check("R8", "framing entry", d, 32'h0A55);
    regRead(2'd0, d);
    check("R8", "next frame clean", d, 32'h0812);
    regRead(2'd3, d);
    check("R8", "sticky framing", d[11:8], 4'b0010);
    regWrite(2'd3, 16'h0200);
  endtask

  task automatic t_break();
    logic [15:0] d;
    @(negedge clk); rxLine = 1'b0;
    repeat (12 * 16) @(negedge clk);
    rxLine = 1'b1;
    repeat (32) @(negedge clk);
    regRead(2'd3, d);
    check("R9", "one break entry", d[5:0], 6'd1);
    check("R9", "sticky break", d[11:8], 4'b0100);
    regRead(2'd0, d);
    check("R9", "break entry", d, 32'h0C00);
    regWrite(2'd3, 16'h0400);
  endtask

  task automatic t_levels();
    logic [15:0] d;
    regWrite(2'd1, 16'h0021 | C_DIRQ | C_ARTS); // irq code1 (4), rts code2 (8)
    for (int i = 0; i < 3; i++) sendFrame(8'(i), 0, 0, 1);
    check("R4", "irq below 4", dataIrq, 0);
    check("R5", "rts active low at 3", rtsPin, 0);
    sendFrame(8'h03, 0, 0, 1);
    check("R4", "irq at 4", dataIrq, 1);
    for (int i = 0; i < 3; i++) sendFrame(8'(i), 0, 0, 1);
    check("R5", "rts still active at 7", rtsPin, 0);
    sendFrame(8'h07, 0, 0, 1);
    check("R5", "rts inactive at 8", rtsPin, 1);
    regRead(2'd0, d);
    check("R5", "rts active at 7", rtsPin, 0);
    regWrite(2'd1, 16'h0021 | C_DIRQ | C_ARTS | C_RHIGH);
    check("R5", "rts active high", rtsPin, 1);
    for (int i = 0; i < 4; i++) regRead(2'd0, d);
    check("R4", "irq falls at 3", dataIrq, 0);
    regWrite(2'd1, C_MRTS);
    check("R5", "manual rts active low", rtsPin, 0);
    flush();
  endtask

  task automatic t_fill();
    logic [15:0] d;
    regWrite(2'd1, 16'h0003 | C_DIRQ);       // level 14
    for (int i = 0; i < 13; i++) sendFrame(8'(i), 0, 0, 1);
    check("R4", "code3 at 13", dataIrq, 0);
    sendFrame(8'd13, 0, 0, 1);
    check("R4", "code3 at 14", dataIrq, 1);
    regWrite(2'd1, 16'h0004 | C_DIRQ);       // level 30
    check("R4", "code4 at 14", dataIrq, 0);
    for (int i = 14; i < 30; i++) sendFrame(8'(i), 0, 0, 1);
    check("R4", "code4 at 30", dataIrq, 1);
    regWrite(2'd1, 16'h0009 | C_DIRQ);       // unlisted code -> 30
    check("R4", "code9 at 30", dataIrq, 1);
    sendFrame(8'd30, 0, 0, 1);
    sendFrame(8'd31, 0, 0, 1);
    regRead(2'd3, d);
    check("R2", "full status", d[7:0], 8'hA0);
    sendFrame(8'hEE, 0, 0, 1);
    regRead(2'd3, d);
    check("R3", "count stays 32", d[7:0], 8'hA0);
    check("R3", "overflow sticky", d[11:8], 4'b1000);
    regRead(2'd0, d);
    check("R3", "head is first", d, 32'h0800);
    for (int i = 1; i < 31; i++) regRead(2'd0, d);
    regRead(2'd0, d);
    check("R3", "last kept entry", d, 32'h081F);
    regWrite(2'd3, 16'h0800);
    regRead(2'd3, d);
    check("R3", "overflow cleared", d[11:8], 4'b0000);
  endtask

  task automatic t_timeout();
    logic [15:0] d;
    regWrite(2'd2, 16'd4);
    regWrite(2'd1, C_TCNT | C_TIRQ);
    sendFrame(8'h41, 0, 0, 1);
    repeat (40) @(negedge clk);
    check("R6", "no timeout early", toutIrq, 0);
    repeat (60) @(negedge clk);
    check("R6", "timeout after idle", toutIrq, 1);
    regRead(2'd0, d);
    check("R6", "timeout cleared on pop", toutIrq, 0);
    regWrite(2'd1, C_TIRQ);
    sendFrame(8'h42, 0, 0, 1);
    repeat (200) @(negedge clk);
    check("R6", "counter disabled", toutIrq, 0);
    flush();
  endtask

  task automatic t_flush();
    logic [15:0] d;
    regWrite(2'd1, 16'h0000);
    sendFrame(8'h66, 0, 0, 0);
    sendFrame(8'h67, 0, 0, 1);
    flush();
    regRead(2'd3, d);
    check("R10", "flush empties", d[7:0], 8'h40);
    check("R10", "flush keeps flags", d[11:8], 4'b0010);
    regWrite(2'd3, 16'h0F00);
  endtask

  task automatic t_pop_empty();
    logic [15:0] d;
    regRead(2'd0, d);
    check("R12", "empty read", d, 0);
    regRead(2'd3, d);
    check("R12", "still empty", d[7:0], 8'h40);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    t_basic();
    t_parity();
    t_frame();
    t_break();
    t_levels();
    t_fill();
    t_timeout();
    t_flush();
    t_pop_empty();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL R1 watchdog: actual hung expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule